// File: doc/BRIEF.md
# YUV to RGB Matrix Converter

This block converts one video pixel per clock from the Y/U/V colour space to R/G/B. It is used between a video decoder or scaler, which delivers limited-range 8-bit luma and chroma samples, and a display path that needs full-range 8-bit RGB. Each output channel is a weighted sum of the three input samples plus an offset. The result is rounded and then saturated into the 8-bit output range.

The conversion matrix is held in twelve programmable slots, loaded one slot per clock through a write port. Slot number = 4 x row + column. Rows are ordered green (row 0), red (row 1), blue (row 2). Columns are ordered Y weight (0), U weight (1), V weight (2), offset (3). Weights are fixed-point values with 10 fractional bits, so 1024 means 1.0. Offsets are in units of 1/16 of an output step, so 16 means +1.0.

After reset the slots hold a standard-definition matrix for studio-range input. The pipeline has a fixed depth: a pixel marked valid on one clock appears at the output, with its own valid flag, three clocks later.

Top module: `ycc_rgb_conv`

## Requirements
- R1: While `rst` is high, and after it is released, `out_valid` is 0 and `out_r`, `out_g` and `out_b` are 0. All twelve slots return to their default values.
- R2: `out_valid` equals `in_valid` delayed by exactly three clocks. A new pixel may be accepted on every clock.
- R3: Each channel is computed as cy·Y + cu·U + cv·V + 64·k, with Y, U and V unsigned. The weights cy, cu and cv are taken from bits 12:0 of their slot as 13-bit two's complement. The offset k is the whole 14-bit slot as two's complement.
- R4: The sum is rounded by adding 512. It is then shifted right by 10 with sign, which is floor division by 1024, so exact halves round upward.
- R5: A rounded result below 0 gives 0 and a result above 255 gives 255.
- R6: Slot 4·r+c drives row r and column c, as laid out in the description. Row 0 feeds `out_g`, row 1 feeds `out_r` and row 2 feeds `out_b`.
- R7: The default slot values, slots 0 to 11 in order, are 0x04A7, 0x1E6F, 0x1CBF, 0x0877, 0x04A7, 0x0000, 0x0662, 0x3211, 0x04A7, 0x0812, 0x0000, 0x2EB1. With these defaults, input (16,128,128) gives RGB (0,0,0) and input (235,128,128) gives (255,255,255).
- R8: A write with `cfg_slot` of 12 to 15 changes no slot.
- R9: A write on clock n applies to pixels accepted from clock n+1 onward. A pixel accepted on the same clock as a write still uses the old value. Without a write, the slots keep their values.
- R10: While `out_valid` is 0, `out_r`, `out_g` and `out_b` keep the value of the last valid result, or 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_slot | input | 4 | Slot number to write |
| cfg_data | input | 14 | Slot value |
| in_valid | input | 1 | Input pixel valid |
| in_y | input | 8 | Luma sample |
| in_u | input | 8 | Blue-difference chroma sample |
| in_v | input | 8 | Red-difference chroma sample |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 8 | Red result |
| out_g | output | 8 | Green result |
| out_b | output | 8 | Blue result |

## Verification
The bench targets five kinds of error:

- **Sign decoding.** Weights such as 0x1E6F and 0x1FFF, and offsets such as 0x3211, are negative. A design that read them as unsigned would give bright, saturated colours where dark ones are expected.
- **Rounding.** A half-gain row is swept across every luma value, both added to and subtracted from an offset. Truncation, or rounding toward zero, would then be off by one on every odd input.
- **Saturation.** All eight 0/255 input corners are driven under the default matrix and under extreme weights. A missing clamp shows up as a wrapped output, for example 255 becoming a small number.
- **Slot order and write handling.** The bench loads a permutation matrix and writes the four unused slot numbers. A swapped row order, or an aliased slot number, moves channels around or corrupts the default matrix.
- **Pipeline timing.** Writes land on the same clock as a pixel, inputs arrive back to back and with gaps, and a reset is applied mid-stream. An off-by-one latency, early use of a new weight, or outputs that change while invalid all show up as a mismatch.

// File: rtl/ycc_rgb_pkg.sv
package ycc_rgb_pkg;
  localparam int ROWS    = 3;               // green, red, blue
  localparam int COLS    = 4;               // Y, U, V weight then offset
  localparam int SLOTS   = ROWS * COLS;
  localparam int SLOT_AW = $clog2(SLOTS);
  localparam int LATENCY = 3;

  // Reset contents of the matrix slots (studio-range SD conversion).
  function automatic logic [15:0] default_slot(input int idx);
    case (idx)
      0:       return 16'h04A7;
      1:       return 16'h1E6F;
      2:       return 16'h1CBF;
      3:       return 16'h0877;
      4:       return 16'h04A7;
      5:       return 16'h0000;
      6:       return 16'h0662;
      7:       return 16'h3211;
      8:       return 16'h04A7;
      9:       return 16'h0812;
      10:      return 16'h0000;
      11:      return 16'h2EB1;
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/ycc_coef_bank.sv
module ycc_coef_bank
  import ycc_rgb_pkg::*;
#(
  parameter int COEF_W  = 13,
  parameter int CONST_W = 14
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   wr_en,
  input  logic [SLOT_AW-1:0]                     wr_slot,
  input  logic [CONST_W-1:0]                     wr_data,
  output logic [ROWS*(COLS-1)-1:0][COEF_W-1:0]   coef_o,
  output logic [ROWS-1:0][CONST_W-1:0]           konst_o
);
  // Every slot is read in parallel each clock, so slots are flops.
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    localparam int          ROW = i / COLS;
    localparam int          COL = i % COLS;
    localparam logic [15:0] DEF = default_slot(i);

    if (COL == COLS - 1) begin : g_const
      logic [CONST_W-1:0] val_q;
      always_ff @(posedge clk) begin
        if (rst)
          val_q <= DEF[CONST_W-1:0];
        else if (wr_en && wr_slot == SLOT_AW'(i))
          val_q <= wr_data;
      end
      assign konst_o[ROW] = val_q;
    end else begin : g_coef
      logic [COEF_W-1:0] val_q;
      always_ff @(posedge clk) begin
        if (rst)
          val_q <= DEF[COEF_W-1:0];
        else if (wr_en && wr_slot == SLOT_AW'(i))
          val_q <= wr_data[COEF_W-1:0];
      end
      assign coef_o[ROW*(COLS-1)+COL] = val_q;
    end
  end
endmodule

// File: rtl/ycc_row_mac.sv
module ycc_row_mac #(
  parameter int DATA_W      = 8,
  parameter int COEF_W      = 13,
  parameter int CONST_W     = 14,
  parameter int FRAC_BITS   = 10,
  parameter int CONST_SHIFT = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_mul,
  input  logic               en_sum,
  input  logic               en_out,
  input  logic [DATA_W-1:0]  y_i,
  input  logic [DATA_W-1:0]  u_i,
  input  logic [DATA_W-1:0]  v_i,
  input  logic [COEF_W-1:0]  cy_i,
  input  logic [COEF_W-1:0]  cu_i,
  input  logic [COEF_W-1:0]  cv_i,
  input  logic [CONST_W-1:0] k_i,
  output logic [DATA_W-1:0]  pix_o
);
  localparam int PROD_W = COEF_W + DATA_W + 1;
  localparam int KSH_W  = CONST_W + CONST_SHIFT;
  localparam int ACC_W  = ((PROD_W > KSH_W) ? PROD_W : KSH_W) + 2;
  localparam logic signed [ACC_W-1:0] RND     = ACC_W'(1) << (FRAC_BITS - 1);
  localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << DATA_W) - 1);

  logic signed [PROD_W-1:0] py_q, pu_q, pv_q;
  logic signed [KSH_W-1:0]  k_q;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [ACC_W-1:0]  scaled;

  function automatic logic signed [PROD_W-1:0] mul(input logic [COEF_W-1:0] c,
                                                   input logic [DATA_W-1:0] d);
    return PROD_W'($signed(c)) * PROD_W'($signed({1'b0, d}));
  endfunction

  // Stage 1: products and offset aligned to the product scale.
  always_ff @(posedge clk) begin
    if (en_mul) begin
      py_q <= mul(cy_i, y_i);
      pu_q <= mul(cu_i, u_i);
      pv_q <= mul(cv_i, v_i);
      k_q  <= KSH_W'($signed(k_i)) <<< CONST_SHIFT;
    end
  end

  // Stage 2: sum with rounding bias.
  always_ff @(posedge clk) begin
    if (en_sum)
      acc_q <= ACC_W'(py_q) + ACC_W'(pu_q) + ACC_W'(pv_q) + ACC_W'(k_q) + RND;
  end

  always_comb scaled = acc_q >>> FRAC_BITS;

  // Stage 3: saturate into the pixel range.
  always_ff @(posedge clk) begin
    if (rst)
      pix_o <= '0;
    else if (en_out) begin
      if (scaled[ACC_W-1])
        pix_o <= '0;
      else if (scaled > PIX_MAX)
        pix_o <= '1;
      else
        pix_o <= scaled[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/ycc_rgb_conv.sv
module ycc_rgb_conv
  import ycc_rgb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int COEF_W      = 13,
  parameter int CONST_W     = 14,
  parameter int FRAC_BITS   = 10,
  parameter int CONST_SHIFT = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [SLOT_AW-1:0] cfg_slot,
  input  logic [CONST_W-1:0] cfg_data,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_y,
  input  logic [DATA_W-1:0]  in_u,
  input  logic [DATA_W-1:0]  in_v,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_r,
  output logic [DATA_W-1:0]  out_g,
  output logic [DATA_W-1:0]  out_b
);
  logic [ROWS*(COLS-1)-1:0][COEF_W-1:0] coef_q;
  logic [ROWS-1:0][CONST_W-1:0]         konst_q;
  logic [ROWS-1:0][DATA_W-1:0]          row_pix;
  logic [LATENCY-1:0]                   vld_q;

  ycc_coef_bank #(.COEF_W(COEF_W), .CONST_W(CONST_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_slot (cfg_slot),
    .wr_data (cfg_data),
    .coef_o  (coef_q),
    .konst_o (konst_q)
  );

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[LATENCY-2:0], in_valid};
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    ycc_row_mac #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .CONST_W(CONST_W),
      .FRAC_BITS(FRAC_BITS), .CONST_SHIFT(CONST_SHIFT)
    ) u_row (
      .clk    (clk),
      .rst    (rst),
      .en_mul (in_valid),
      .en_sum (vld_q[0]),
      .en_out (vld_q[1]),
      .y_i    (in_y),
      .u_i    (in_u),
      .v_i    (in_v),
      .cy_i   (coef_q[r*(COLS-1)+0]),
      .cu_i   (coef_q[r*(COLS-1)+1]),
      .cv_i   (coef_q[r*(COLS-1)+2]),
      .k_i    (konst_q[r]),
      .pix_o  (row_pix[r])
    );
  end

  assign out_valid = vld_q[LATENCY-1];
  assign out_g     = row_pix[0];
  assign out_r     = row_pix[1];
  assign out_b     = row_pix[2];
endmodule

// File: rtl/ycc_rgb_chk.sv
module ycc_rgb_chk
  import ycc_rgb_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int COEF_W  = 13,
  parameter int CONST_W = 14
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic                                 cfg_we,
  input logic [SLOT_AW-1:0]                   cfg_slot,
  input logic                                 in_valid,
  input logic                                 out_valid,
  input logic [DATA_W-1:0]                    out_r,
  input logic [DATA_W-1:0]                    out_g,
  input logic [DATA_W-1:0]                    out_b,
  input logic [ROWS*(COLS-1)-1:0][COEF_W-1:0] coef_q,
  input logic [ROWS-1:0][CONST_W-1:0]         konst_q
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)             age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_r == '0 && out_g == '0 && out_b == '0));

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  p_bad_slot_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_slot >= SLOT_AW'(SLOTS)) |=> ($stable(coef_q) && $stable(konst_q)));

  p_slots_keep_r9: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ($stable(coef_q) && $stable(konst_q)));

  p_hold_r_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_r));
  p_hold_g_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_g));
  p_hold_b_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_b));
endmodule

bind ycc_rgb_conv ycc_rgb_chk #(
  .DATA_W(DATA_W), .COEF_W(COEF_W), .CONST_W(CONST_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_slot  (cfg_slot),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_r     (out_r),
  .out_g     (out_g),
  .out_b     (out_b),
  .coef_q    (coef_q),
  .konst_q   (konst_q)
);

// File: tb/test_ycc_rgb_conv.sv
`timescale 1ns/1ps
module test_ycc_rgb_conv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_slot = '0;
  logic [13:0] cfg_data = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_y = '0, in_u = '0, in_v = '0;
  logic        out_valid;
  logic [7:0]  out_r, out_g, out_b;

  int tests = 0;
  int fails = 0;
  int ms[16];
  int q_v[$], q_r[$], q_g[$], q_b[$];
  string q_t[$];
  int hold_r, hold_g, hold_b;
  int seed = 7;

  ycc_rgb_conv i_ycc_rgb_conv (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_y(in_y), .in_u(in_u), .in_v(in_v),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  always #4 clk = ~clk;

  function automatic int dflt(int i);
    case (i)
      0: return 'h04A7;  1: return 'h1E6F;  2: return 'h1CBF;  3: return 'h0877;
      4: return 'h04A7;  5: return 'h0000;  6: return 'h0662;  7: return 'h3211;
      8: return 'h04A7;  9: return 'h0812; 10: return 'h0000; 11: return 'h2EB1;
      default: return 0;
    endcase
  endfunction

  function automatic int sx(int val, int w);
    int t = val & ((1 << w) - 1);
    if (t >= (1 << (w - 1))) t = t - (1 << w);
    return t;
  endfunction

  // Row 0 = green, 1 = red, 2 = blue (R6); R3/R4/R5 arithmetic.
  function automatic int ref_row(int row, int y, int u, int v);
    int acc;
    acc = sx(ms[4*row], 13) * y + sx(ms[4*row+1], 13) * u + sx(ms[4*row+2], 13) * v
        + sx(ms[4*row+3], 14) * 64;
    acc = (acc + 512) >>> 10;
    if (acc < 0) acc = 0;
    if (acc > 255) acc = 255;
    return acc;
  endfunction

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 'hFFFF;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit iv, int y, int u, int v, bit we, int slot, int data, string tag);
    int ev, er, eg, eb;
    string et;
    in_valid = iv; in_y = 8'(y); in_u = 8'(u); in_v = 8'(v);
    cfg_we = we; cfg_slot = 4'(slot); cfg_data = 14'(data);
    q_v.push_back(int'(iv));
    q_r.push_back(iv ? ref_row(1, y, u, v) : 0);
    q_g.push_back(iv ? ref_row(0, y, u, v) : 0);
    q_b.push_back(iv ? ref_row(2, y, u, v) : 0);
    q_t.push_back(tag);
    if (we && slot < 12) ms[slot] = data & 'h3FFF;   // R8: high slots ignored
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    if (q_v.size() == 3) begin
      ev = q_v.pop_front(); er = q_r.pop_front(); eg = q_g.pop_front();
      eb = q_b.pop_front(); et = q_t.pop_front();
      check("R2", "out_valid", int'(out_valid), ev);
      if (ev != 0) begin
        hold_r = er; hold_g = eg; hold_b = eb;
        check(et, "out_r", int'(out_r), er);
        check(et, "out_g", int'(out_g), eg);
        check(et, "out_b", int'(out_b), eb);
      end else begin
        check("R10", "held out_r", int'(out_r), hold_r);
        check("R10", "held out_g", int'(out_g), hold_g);
        check("R10", "held out_b", int'(out_b), hold_b);
      end
    end
  endtask

  task automatic pix(int y, int u, int v, string tag);
    step(1'b1, y, u, v, 1'b0, 0, 0, tag);
  endtask

  task automatic wr(int slot, int data, string tag);
    step(1'b0, 0, 0, 0, 1'b1, slot, data, tag);
  endtask

  task automatic flush(string tag);
    repeat (3) step(1'b0, 0, 0, 0, 1'b0, 0, 0, tag);
  endtask

  task automatic lit(int r, int g, int b, string tag);
    check(tag, "literal out_r", int'(out_r), r);
    check(tag, "literal out_g", int'(out_g), g);
    check(tag, "literal out_b", int'(out_b), b);
  endtask

  task automatic reset_dut();
    rst = 1'b1; in_valid = 1'b0; cfg_we = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) ms[i] = (i < 12) ? dflt(i) : 0;
    q_v.delete(); q_r.delete(); q_g.delete(); q_b.delete(); q_t.delete();
    hold_r = 0; hold_g = 0; hold_b = 0;
    for (int i = 0; i < 2; i++) begin
      q_v.push_back(0); q_r.push_back(0); q_g.push_back(0); q_b.push_back(0);
      q_t.push_back("R1");
    end
    check("R1", "out_valid after reset", int'(out_valid), 0);
    lit(0, 0, 0, "R1");
  endtask

  initial begin
    #(100000 * 8);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    reset_dut();

    // R7: default matrix, black and white points
    pix(16, 128, 128, "R7"); flush("R10"); lit(0, 0, 0, "R7");
    pix(235, 128, 128, "R7"); flush("R10"); lit(255, 255, 255, "R7");

    // R5: input corners under the default matrix
    for (int i = 0; i < 8; i++)
      pix(i[0] ? 255 : 0, i[1] ? 255 : 0, i[2] ? 255 : 0, "R5");
    flush("R10");

    // R3: mixed stream with gaps
    for (int k = 0; k < 400; k++) begin
      int s = rnd();
      int t = rnd();
      step((s & 3) != 0, t & 255, (t >> 8) & 255, s >> 8 & 255, 1'b0, 0, 0, "R3");
    end
    // R2: back-to-back pixels
    for (int k = 0; k < 40; k++) begin
      int t = rnd();
      pix(t & 255, (t >> 8) & 255, (k * 37) & 255, "R2");
    end
    flush("R10");

    // R8: unused slot numbers must not alter the matrix
    for (int s = 12; s < 16; s++) wr(s, 'h3FFF, "R8");
    pix(235, 128, 128, "R8"); flush("R10"); lit(255, 255, 255, "R8");
    for (int k = 0; k < 20; k++) begin
      int t = rnd();
      pix(t & 255, (t >> 4) & 255, (t >> 8) & 255, "R8");
    end
    flush("R10");

    // R6: permutation matrix G=U, R=V, B=Y
    for (int s = 0; s < 12; s++) wr(s, 0, "R6");
    wr(1, 1024, "R6"); wr(6, 1024, "R6"); wr(8, 1024, "R6");
    pix(10, 20, 30, "R6"); flush("R10"); lit(30, 20, 10, "R6");
    for (int k = 0; k < 30; k++) begin
      int t = rnd();
      pix(t & 255, (t >> 4) & 255, (t >> 8) & 255, "R6");
    end
    flush("R10");

    // R4: half-gain rows exercise rounding of exact halves
    wr(0, 512, "R4"); wr(1, 0, "R4"); wr(2, 0, "R4"); wr(3, 0, "R4");
    wr(4, 'h1E00, "R4"); wr(5, 0, "R4"); wr(6, 0, "R4"); wr(7, 3200, "R4");
    wr(8, 0, "R4"); wr(9, 0, "R4"); wr(10, 'h1FFF, "R4"); wr(11, 0, "R4");
    pix(1, 0, 0, "R4"); flush("R10"); lit(200, 1, 0, "R4");
    for (int y = 0; y < 256; y++) pix(y, 255 - y, (y * 7) & 255, "R4");
    flush("R10");

    // R9: a pixel on the write clock uses the old weight
    step(1'b1, 100, 100, 100, 1'b1, 0, 1024, "R9");
    flush("R10"); lit(150, 50, 0, "R9");
    pix(100, 100, 100, "R9"); flush("R10"); lit(150, 100, 0, "R9");
    for (int k = 0; k < 20; k++) begin
      int t = rnd();
      step(1'b1, t & 255, (t >> 4) & 255, (t >> 8) & 255, 1'b1, k % 12, rnd() & 'h3FFF, "R9");
    end
    flush("R10");

    // R5: extreme weights force both saturation limits
    wr(0, 4095, "R5"); wr(1, 4095, "R5"); wr(2, 4095, "R5"); wr(3, 'h1FFF, "R5");
    wr(4, 'h1000, "R5"); wr(5, 'h1000, "R5"); wr(6, 'h1000, "R5"); wr(7, 'h2000, "R5");
    wr(8, 4095, "R5"); wr(9, 'h1000, "R5"); wr(10, 0, "R5"); wr(11, 0, "R5");
    for (int i = 0; i < 8; i++)
      pix(i[0] ? 255 : 0, i[1] ? 255 : 0, i[2] ? 255 : 0, "R5");
    for (int k = 0; k < 40; k++) begin
      int t = rnd();
      pix(t & 255, (t >> 4) & 255, (t >> 8) & 255, "R5");
    end
    flush("R10");
    pix(0, 0, 0, "R5"); flush("R10"); lit(0, 255, 0, "R5");

    // R1: reset with pixels in flight restores defaults and clears outputs
    pix(200, 50, 60, "R1");
    pix(201, 51, 61, "R1");
    reset_dut();
    pix(235, 128, 128, "R1"); flush("R10"); lit(255, 255, 255, "R1");
    pix(16, 128, 128, "R1"); flush("R10"); lit(0, 0, 0, "R1");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule